// File: doc/BRIEF.md
# Supply Supervisor Reset Stretcher

This block turns two digitized supply-level flags into an internal alarm that keeps a card interface inactive while its supply ramps up or collapses. One flag reports that the supply is above a lower threshold. The other reports that it is above that threshold plus a hysteresis margin. Both flags come from analog comparators that are not part of this block, so they are first synchronized into the block clock.

The alarm drops only after the upper flag has been seen high for an unbroken stretch of `STRETCH_CYCLES` clocks. The alarm rises again as soon as the lower flag goes low. While the alarm is high, activation requests from the system controller are refused. An accepted request opens an interface session, shown on `active_o`.

If the supply falls while a session is open, the block emits a one-cycle request to the contact deactivation sequencer and closes the session. The block takes no account of the order in which supplies appear: reset and any flag pattern leave it in the alarm state until the release condition is met.

Top module: `supply_reset_stretcher`

## Requirements
- R1: After reset, `alarm_o` and `act_inhibit_o` are 1, and `active_o` and `deact_req_o` are 0.
- R2: While the synchronized lower flag is 0, `alarm_o` is 1 on the following cycle, whatever the upper flag and `act_req_i` do.
- R3: With the lower flag at 1 and the upper flag at 0, an asserted alarm stays asserted indefinitely.
- R4: With both flags held at 1 from cycle C (alarm asserted), `alarm_o` falls after the clock edge C+`SYNC_STAGES`+`STRETCH_CYCLES` and not before.
- R5: If the upper flag drops during the stretch, the count restarts from zero, and the release comes `SYNC_STAGES`+`STRETCH_CYCLES` edges after the flag returns.
- R6: Once released, the alarm stays low while the lower flag stays 1, even with the upper flag at 0.
- R7: When the lower flag falls with the alarm released, `alarm_o` rises after edge C+`SYNC_STAGES`+1.
- R8: `act_inhibit_o` equals `alarm_o`. An `act_req_i` seen while the alarm is high leaves `active_o` at 0.
- R9: An `act_req_i` seen on an edge with the alarm low and the supply good sets `active_o` after that edge.
- R10: `deact_req_o` is a one-cycle pulse on the edge where the alarm re-asserts, only if `active_o` was 1. On the same edge `active_o` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lvl_lo_i | input | 1 | Supply above lower threshold (asynchronous) |
| lvl_hi_i | input | 1 | Supply above threshold plus hysteresis (asynchronous) |
| act_req_i | input | 1 | Activation request from system controller |
| alarm_o | output | 1 | Internal alarm, high holds the interface inactive |
| act_inhibit_o | output | 1 | Activation refused while high |
| active_o | output | 1 | Interface session open |
| deact_req_o | output | 1 | One-cycle trigger for the contact deactivation sequence |

## Verification
The bench drops the upper flag for a single cycle in the middle of a stretch. A design that pauses its counter, or ignores the drop, would release the alarm several cycles early. It also lets the upper flag sag after release: a design without hysteresis would re-assert the alarm there. Activation is requested throughout a long alarm period; a leaky gate would open a session during the alarm. The supply is dropped twice, once with a session open and once without: a pulse in the second case, a pulse longer than one cycle, or an off-by-one in the synchronizer latency would each show as a mismatch in the expected cycle.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int unsigned NUM_LVL = 2;
  localparam int unsigned LVL_LO  = 0;
  localparam int unsigned LVL_HI  = 1;

  typedef logic [NUM_LVL-1:0] lvl_vec_t;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;  // reads as supply low
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/srs_stretch.sv
module srs_stretch #(
  parameter int unsigned STRETCH_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lo_i,
  input  logic hi_i,
  output logic alarm_o,
  output logic drop_o
);
  localparam int unsigned CW = srs_pkg::cnt_width(STRETCH_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(STRETCH_CYCLES - 1);

  logic          alarm_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= 1'b1;
      cnt_q   <= '0;
    end else if (!lo_i) begin
      alarm_q <= 1'b1;
      cnt_q   <= '0;
    end else if (alarm_q) begin
      if (!hi_i) begin
        cnt_q <= '0;  // back inside the band: restart
      end else if (cnt_q == LAST) begin
        alarm_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign alarm_o = alarm_q;
  assign drop_o  = !lo_i && !alarm_q;
endmodule

// File: rtl/srs_session.sv
module srs_session (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alarm_i,
  input  logic drop_i,
  input  logic act_req_i,
  output logic active_o,
  output logic deact_o
);
  logic active_q, deact_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      deact_q  <= 1'b0;
    end else begin
      deact_q <= drop_i && active_q;
      if (drop_i)                     active_q <= 1'b0;
      else if (act_req_i && !alarm_i) active_q <= 1'b1;
    end
  end

  assign active_o = active_q;
  assign deact_o  = deact_q;
endmodule

// File: rtl/supply_reset_stretcher.sv
module supply_reset_stretcher #(
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned STRETCH_CYCLES = 2_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_lo_i,
  input  logic lvl_hi_i,
  input  logic act_req_i,
  output logic alarm_o,
  output logic act_inhibit_o,
  output logic active_o,
  output logic deact_req_o
);
  import srs_pkg::*;

  lvl_vec_t lvl_raw, lvl_sync;
  logic     lo_sync, hi_sync, alarm, drop;

  assign lvl_raw[LVL_LO] = lvl_lo_i;
  assign lvl_raw[LVL_HI] = lvl_hi_i;

  srs_sync #(.WIDTH(NUM_LVL), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lvl_raw),
    .q_o   (lvl_sync)
  );

  assign lo_sync = lvl_sync[LVL_LO];
  assign hi_sync = lvl_sync[LVL_HI];

  srs_stretch #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_stretch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lo_i   (lo_sync),
    .hi_i   (hi_sync),
    .alarm_o(alarm),
    .drop_o (drop)
  );

  srs_session u_session (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .alarm_i  (alarm),
    .drop_i   (drop),
    .act_req_i(act_req_i),
    .active_o (active_o),
    .deact_o  (deact_req_o)
  );

  assign alarm_o       = alarm;
  assign act_inhibit_o = alarm;
endmodule

// File: rtl/srs_chk.sv
module srs_chk #(
  parameter int unsigned STRETCH_CYCLES = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic lo_s_i,
  input logic hi_s_i,
  input logic alarm_o,
  input logic active_o,
  input logic deact_req_o
);
  localparam int unsigned CW = srs_pkg::cnt_width(STRETCH_CYCLES);
  localparam logic [CW-1:0] SAT = CW'(STRETCH_CYCLES);

  logic [CW-1:0] good_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 good_cnt_q <= '0;
    else if (!(lo_s_i && hi_s_i)) good_cnt_q <= '0;
    else if (good_cnt_q != SAT)  good_cnt_q <= good_cnt_q + 1'b1;
  end

  p_low_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lo_s_i |=> alarm_o);

  p_release_after_stretch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alarm_o) |-> (good_cnt_q == SAT));

  p_hysteresis_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alarm_o && lo_s_i) |=> !alarm_o);

  p_no_act_in_alarm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o && !active_o) |=> !active_o);

  p_active_needs_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> !alarm_o);

  p_deact_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deact_req_o |=> !deact_req_o);

  p_deact_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deact_req_o |-> ($rose(alarm_o) && !active_o && $past(active_o)));
endmodule

bind supply_reset_stretcher srs_chk #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lo_s_i     (lo_sync),
  .hi_s_i     (hi_sync),
  .alarm_o    (alarm_o),
  .active_o   (active_o),
  .deact_req_o(deact_req_o)
);

// File: tb/supply_reset_stretcher_tb.sv
module supply_reset_stretcher_tb;
  localparam int unsigned SYNC = 2;
  localparam int unsigned STR  = 8;
  localparam int unsigned LAT  = SYNC + STR;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic lvl_lo_i = 1'b0, lvl_hi_i = 1'b0, act_req_i = 1'b0;
  logic alarm_o, act_inhibit_o, active_o, deact_req_o;

  always #2.5 clk_i = ~clk_i;

  supply_reset_stretcher #(.SYNC_STAGES(SYNC), .STRETCH_CYCLES(STR)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_lo_i(lvl_lo_i), .lvl_hi_i(lvl_hi_i),
    .act_req_i(act_req_i), .alarm_o(alarm_o), .act_inhibit_o(act_inhibit_o),
    .active_o(active_o), .deact_req_o(deact_req_o)
  );

  typedef struct {
    int    cyc;
    logic  a;
    logic  act;
    logic  d;
    string r;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   cyc = 0;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic push(input int k, input logic a, input logic act, input logic d, input string r);
    exp_t x;
    x.cyc = cyc + k; x.a = a; x.act = act; x.d = d; x.r = r;
    q.push_back(x);
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // monitor: pop and compare at the cycle each item is due
  always @(negedge clk_i) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      e = q.pop_front();
      n_chk++;
      if (e.cyc < cyc) begin
        n_fail++;
        $display("FAIL %s: item for cycle %0d missed (now %0d)", e.r, e.cyc, cyc);
      end else if (alarm_o !== e.a || act_inhibit_o !== e.a ||
                   active_o !== e.act || deact_req_o !== e.d) begin
        n_fail++;
        $display("FAIL %s: cyc %0d alarm/inh/active/deact=%b%b%b%b expected %b%b%b%b",
                 e.r, cyc, alarm_o, act_inhibit_o, active_o, deact_req_o,
                 e.a, e.a, e.act, e.d);
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    hold(3);
    rst_ni = 1'b1;
    // R1 reset state
    n_chk++;
    if (alarm_o !== 1'b1 || act_inhibit_o !== 1'b1 || active_o !== 1'b0 || deact_req_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: alarm/inh/active/deact=%b%b%b%b expected 1100",
               alarm_o, act_inhibit_o, active_o, deact_req_o);
    end

    // R2, R8: lower flag low, upper high, activation requested throughout
    lvl_hi_i = 1'b1; act_req_i = 1'b1;
    for (int k = 1; k <= 20; k++) push(k, 1, 0, 0, "R2_R8");
    hold(20);
    act_req_i = 1'b0;

    // R3: inside the hysteresis band
    lvl_lo_i = 1'b1; lvl_hi_i = 1'b0;
    for (int k = 1; k <= 20; k++) push(k, 1, 0, 0, "R3");
    hold(20);

    // R5: one-cycle dip of the upper flag mid-stretch
    lvl_hi_i = 1'b1;
    for (int k = 1; k <= 6; k++) push(k, 1, 0, 0, "R5");
    hold(6);
    lvl_hi_i = 1'b0;
    push(1, 1, 0, 0, "R5");
    hold(1);
    lvl_hi_i = 1'b1;
    for (int k = 1; k < LAT; k++) push(k, 1, 0, 0, "R5");
    push(LAT, 0, 0, 0, "R5");
    hold(LAT);

    // R6: upper flag sags after release
    lvl_hi_i = 1'b0;
    for (int k = 1; k <= 15; k++) push(k, 0, 0, 0, "R6");
    hold(15);

    // R9: accepted activation
    act_req_i = 1'b1;
    push(1, 0, 1, 0, "R9");
    hold(1);
    act_req_i = 1'b0;
    for (int k = 1; k <= 3; k++) push(k, 0, 1, 0, "R9");
    hold(3);

    // R7, R10: supply falls with session open
    lvl_lo_i = 1'b0;
    push(1, 0, 1, 0, "R7");
    push(2, 0, 1, 0, "R7");
    push(3, 1, 0, 1, "R10");
    for (int k = 4; k <= 6; k++) push(k, 1, 0, 0, "R10");
    hold(6);

    // R4: clean power-up with both flags together
    lvl_lo_i = 1'b1; lvl_hi_i = 1'b1;
    for (int k = 1; k < LAT; k++) push(k, 1, 0, 0, "R4");
    push(LAT, 0, 0, 0, "R4");
    push(LAT + 1, 0, 0, 0, "R4");
    hold(LAT + 2);

    // R10: supply falls with no session, no pulse
    lvl_lo_i = 1'b0; lvl_hi_i = 1'b0;
    push(1, 0, 0, 0, "R7");
    push(2, 0, 0, 0, "R7");
    push(3, 1, 0, 0, "R10");
    push(4, 1, 0, 0, "R10");
    hold(6);

    done = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
    end
  end
endmodule